// File: doc/BRIEF.md
# Ling Pseudo-Carry Lookahead Adder

This block adds two N-bit operands and a carry-in, with N a multiple of four. It does not carry true carries through its lookahead. It carries Ling pseudo-carries. Each pseudo-carry h(i) uses transmit terms one position lower than a plain lookahead term would, because a generate implies its own transmit. The true carry into bit i is rebuilt with one AND, c(i) = t(i-1) & h(i). Here g = x & y and t = x | y for each bit.

Pseudo-carries are formed four bit positions at a time. Each four-bit group takes the pseudo-carry at its base and the transmit bit just below it. From these it produces the four pseudo-carries above its base in flat AND-OR form. The top one is the pseudo-carry entering the next group, so the chain skips from group to group. The carry-in enters as the pseudo-carry at bit 0, with a transmit of cin assumed below bit 0, so that c(0) = cin.

The sum and the carry-out are registered. A result appears one clock after its operands are presented.

Top module: `ling_adder`

## Requirements
- R1: One rising edge after operands `op_a`, `op_b` and `cin` are sampled with `rst` low, `sum` equals (`op_a` + `op_b` + `cin`) mod 2^WIDTH.
- R2: `cout` equals bit WIDTH of `op_a` + `op_b` + `cin`, registered in the same cycle as `sum`.
- R3: Reset is synchronous and active high. After a rising edge with `rst` high, `sum` and `cout` are both zero, whatever the operands are.
- R4: With `op_a` all ones, `op_b` zero and `cin` = 1, the carry-in travels through every group: `sum` = 0 and `cout` = 1.
- R5: A carry generated at the top bit 4k+3 of group k, with both operands holding only that bit, enters group k+1: `sum` has only bit 4k+4 set, or `cout` = 1 for the last group.
- R6: When `op_a` equals `op_b` and `cin` = 0, every transmitting bit also generates. `sum` then equals `op_a` shifted left by one and `cout` equals the operand's top bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| cin | input | 1 | Carry-in |
| sum | output | WIDTH | Registered sum |
| cout | output | 1 | Registered carry-out |

## Verification
The bench builds the adder with WIDTH = 8, which makes two lookahead groups and one group-to-group skip. At that width, every combination of both operands and the carry-in, 2^17 cases, can be applied in turn and compared with a plain integer addition. That sweep covers every pattern of generate, transmit and kill across the group boundary. Directed cases for reset, full propagation, boundary-crossing generates and equal operands are applied on top of the sweep.

// File: rtl/ling_pkg.sv
package ling_pkg;
  localparam int unsigned GRP = 4;

  typedef struct packed {
    logic g;
    logic t;
  } gt_t;
endpackage

// File: rtl/ling_gt.sv
module ling_gt #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0]           x,
  input  logic [WIDTH-1:0]           y,
  output ling_pkg::gt_t [WIDTH-1:0]  gt
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign gt[i].g = x[i] & y[i];
    assign gt[i].t = x[i] | y[i];
  end
endmodule

// File: rtl/ling_group.sv
module ling_group
  import ling_pkg::*;
(
  input  gt_t [GRP-1:0] gt,
  input  logic          t_below,
  input  logic          h_base,
  output logic [GRP:1]  h_up
);
  logic [GRP:0] t_ext;

  assign t_ext[0] = t_below;
  for (genvar j = 0; j < GRP; j++) begin : g_t
    assign t_ext[j+1] = gt[j].t;
  end

  always_comb begin
    for (int j = 1; j <= GRP; j++) begin
      logic acc;
      logic prod;
      acc  = gt[j-1].g;
      prod = 1'b1;
      for (int m = 1; m < j; m++) begin
        prod = prod & t_ext[j-m];
        acc  = acc | (prod & gt[j-1-m].g);
      end
      prod = prod & t_ext[0];
      acc  = acc | (prod & h_base);
      h_up[j] = acc;
    end
  end
endmodule

// File: rtl/ling_sum.sv
module ling_sum
  import ling_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  gt_t [WIDTH-1:0]  gt,
  input  logic             t_low,
  input  logic [WIDTH:0]   h,
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  output logic [WIDTH-1:0] s,
  output logic             c_top
);
  logic [WIDTH:0] t_ext;
  logic [WIDTH:0] c;

  assign t_ext[0] = t_low;
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign t_ext[i+1] = gt[i].t;
  end

  for (genvar i = 0; i <= WIDTH; i++) begin : g_carry
    assign c[i] = t_ext[i] & h[i];
  end

  assign s     = x ^ y ^ c[WIDTH-1:0];
  assign c_top = c[WIDTH];

  // R5: the carries rebuilt from Ling pseudo-carries must obey the plain ripple relation.
  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      assert_ripple_consistent_R5: assert (c[i+1] == (gt[i].g | (gt[i].t & c[i])));
    end
  end
endmodule

// File: rtl/ling_adder.sv
module ling_adder
  import ling_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int unsigned NGRP = WIDTH / GRP;

  gt_t  [WIDTH-1:0] gt;
  logic [WIDTH:0]   h;
  logic [WIDTH-1:0] s_comb;
  logic             c_comb;

  initial begin
    assert_width_multiple: assert (WIDTH % GRP == 0 && WIDTH >= GRP);
  end

  ling_gt #(.WIDTH(WIDTH)) u_gt (.x(op_a), .y(op_b), .gt(gt));

  assign h[0] = cin;

  for (genvar k = 0; k < NGRP; k++) begin : g_grp
    logic t_below;
    if (k == 0) begin : g_first
      assign t_below = cin;
    end else begin : g_next
      assign t_below = gt[k*GRP-1].t;
    end
    ling_group u_group (
      .gt      (gt[k*GRP +: GRP]),
      .t_below (t_below),
      .h_base  (h[k*GRP]),
      .h_up    (h[k*GRP+1 +: GRP])
    );
  end

  ling_sum #(.WIDTH(WIDTH)) u_sum (
    .gt    (gt),
    .t_low (cin),
    .h     (h),
    .x     (op_a),
    .y     (op_b),
    .s     (s_comb),
    .c_top (c_comb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum  <= '0;
      cout <= 1'b0;
    end else begin
      sum  <= s_comb;
      cout <= c_comb;
    end
  end

  logic past_ok;
  always_ff @(posedge clk) past_ok <= 1'b1;

  assert_sum_R1: assert property (@(posedge clk) disable iff (rst || !past_ok)
    1'b1 |=> (sum == WIDTH'($past(op_a) + $past(op_b) + WIDTH'($past(cin)))));

  assert_cout_R2: assert property (@(posedge clk) disable iff (rst || !past_ok)
    1'b1 |=> ({1'b0, $past(op_a)} + {1'b0, $past(op_b)} + (WIDTH+1)'($past(cin))) >> WIDTH
             == (WIDTH+1)'(cout));

  assert_reset_R3: assert property (@(posedge clk)
    rst |=> (sum == '0 && cout == 1'b0));

  assert_full_propagate_R4: assert property (@(posedge clk) disable iff (rst)
    (op_a == '1 && op_b == '0 && cin) |=> (sum == '0 && cout));
endmodule

// File: tb/test_ling_adder.sv
module test_ling_adder;
  localparam int W = 8;
  localparam time PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum;
  logic         cout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  ling_adder #(.WIDTH(W)) i_ling_adder (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .cin(cin), .sum(sum), .cout(cout)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic ci);
    op_a = a; op_b = b; cin = ci;
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    op_a = 8'hA5; op_b = 8'h7E; cin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R3 reset holds outputs", {cout, sum}, '0);
    rst = 1'b0;

    // R1 R2: exhaustive sweep, expected values from integer addition
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        for (int c = 0; c < 2; c++) begin
          int e;
          apply(W'(a), W'(b), c[0]);
          e = a + b + c;
          check("R1 sum", {1'b0, sum}, {1'b0, W'(e)});
          check("R2 cout", {{W{1'b0}}, cout}, {{W{1'b0}}, e[W]});
        end
      end
    end

    // R4: carry-in through all ones
    apply('1, '0, 1'b1);
    check("R4 full propagate", {cout, sum}, {1'b1, {W{1'b0}}});

    // R5: generate at the top bit of each group crosses into the next one
    for (int k = 0; k < W / 4; k++) begin
      logic [W:0] e5;
      e5 = '0;
      e5[4*k+4] = 1'b1;
      apply(W'(1) << (4*k+3), W'(1) << (4*k+3), 1'b0);
      check("R5 group crossing", {cout, sum}, e5);
    end

    // R6: equal operands double the value
    for (int v = 0; v < (1 << W); v += 37) begin
      apply(W'(v), W'(v), 1'b0);
      check("R6 equal operands", {cout, sum}, (W+1)'(v) << 1);
    end

    // R3: reset again while operands are nonzero
    op_a = '1; op_b = '1; cin = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R3 reset mid-run", {cout, sum}, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", {cout, sum}, {1'b1, {(W-1){1'b1}}, 1'b1});

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule